// File: doc/BRIEF.md
# Per-Channel Trigger Comparator Bank

This block is the trigger unit of an internal logic analyzer. It watches a parameterised number of probe channels, all the same parameterised width. Each channel has one comparator of its own. The comparator tests the live channel value against a programmed reference, using an operator chosen for that channel. A global combiner then merges the per-channel results into one trigger condition. Depending on the mode, it takes the AND or the OR of all the comparator results. In a third mode it ignores every comparator and uses a synchronized external trigger input instead.

The trigger output is a single-cycle pulse. It is produced only while the arm input is high. Once it has fired, it stays quiet until arm is dropped and raised again. Capture memory and host readout sit outside this block; they use the pulse to freeze a capture.

Top module: `trig_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every comparator result clears and the fired state clears. During reset, trig_out is therefore 0 in the AND, OR and external modes.
- R2: Each channel's operator is a 3-bit field at bits [3c+2:3c] of chan_op. Code 0 always matches and code 1 never matches. Code 7 also never matches.
- R3: Code 2 matches when the sample equals the reference. Code 6 matches when they differ. The reference for channel c is bits [W*c+W-1:W*c] of chan_ref, with the same layout as chan_sample.
- R4: The ordered operators compare unsigned and take the sample as the left operand. Code 3 matches on sample <= reference, code 4 on sample >= reference, and code 5 on sample > reference.
- R5: With trig_mode = 0, the condition is true only when every channel's comparator matches.
- R6: With trig_mode = 1, the condition is true when at least one channel's comparator matches.
- R7: With trig_mode = 2, the comparators have no effect and the condition is the external trigger after a two-flop synchronizer. A high level on ext_trig, first sampled at clock edge k, raises trig_out after edge k+1. With trig_mode = 3, trig_out never fires.
- R8: trig_out is 0 whenever arm is 0.
- R9: While arm stays high, trig_out is high for exactly one cycle: the first cycle in which the condition is true. After that it stays low, even if the condition stays true, until arm goes low for at least one clock edge and rises again.
- R10: Comparator results are registered. A sample that matches at clock edge k can raise trig_out only after edge k, never in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_sample | input | NUM_CH*CH_W | Live probe samples, channel c at [W*c+W-1:W*c] |
| chan_op | input | NUM_CH*3 | Per-channel operator codes, channel c at [3c+2:3c] |
| chan_ref | input | NUM_CH*CH_W | Per-channel reference values |
| trig_mode | input | 2 | 0 AND, 1 OR, 2 external, 3 disabled |
| ext_trig | input | 1 | Asynchronous external trigger level |
| arm | input | 1 | Trigger enable; a low level re-arms after firing |
| trig_out | output | 1 | Single-cycle trigger pulse |

## Verification
Some properties are checked by assertions on every cycle:
- The always-true operator and the never-true operators (codes 1 and 7) produce the correct registered result.
- The output is never high while arm is low.
- The output never stays high for two consecutive cycles.
- In external mode, a pulse only occurs with the synchronized external level high.
- In the disabled mode, no pulse occurs.

Other behaviour only the bench's scenarios can show:
- The results of the ordered and equality operators, which the bench sweeps over every operator, sample and reference of a 3-bit channel.
- The AND and OR reductions across channels.
- The exact two-edge latency of the external path and the one-edge latency of a sample match.
- The re-arm sequence after a pulse.

// File: rtl/trig_pkg.sv
// Shared encodings for the trigger comparator bank.
// Assumes: operator codes are 3 bits wide and the mode select is 2 bits wide.
package trig_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_TRUE  = 3'd0,
        OP_FALSE = 3'd1,
        OP_EQ    = 3'd2,
        OP_LE    = 3'd3,
        OP_GE    = 3'd4,
        OP_GT    = 3'd5,
        OP_NE    = 3'd6,
        OP_RSVD  = 3'd7
    } cmp_op_e;

    typedef enum logic [1:0] {
        MODE_AND  = 2'd0,
        MODE_OR   = 2'd1,
        MODE_EXT  = 2'd2,
        MODE_NONE = 2'd3
    } trig_mode_e;
endpackage

// File: rtl/trig_sync.sv
// Two-flop synchronizer that brings the asynchronous external trigger into the clock domain.
// Assumes: the input is a level that stays stable for at least two clock periods.
module trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic stage1_q;
    logic stage2_q;

    // Shift the asynchronous level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/trig_cmp.sv
// One channel comparator: tests the sample against the reference with the
// selected operator and registers the result.
// Assumes: unsigned values; operator code 7 is treated as never-match.
module trig_cmp
    import trig_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    sample,
    input  logic [W-1:0]    refv,
    input  logic [OP_W-1:0] op,
    output logic            hit
);
    logic match;

    // Evaluate the selected operator on the live sample.
    always_comb begin
        case (cmp_op_e'(op))
            OP_TRUE:  match = 1'b1;
            OP_EQ:    match = (sample == refv);
            OP_LE:    match = (sample <= refv);
            OP_GE:    match = (sample >= refv);
            OP_GT:    match = (sample >  refv);
            OP_NE:    match = (sample != refv);
            default:  match = 1'b0;
        endcase
    end

    // Register the comparison so the trigger path starts on a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= match;
    end

    // R2: the always-true operator yields a match on the next edge.
    assert_op_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TRUE) |=> hit);

    // R2: the never-true operators (code 1 and code 7) yield no match on the next edge.
    assert_op_false_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_FALSE || op == OP_RSVD) |=> !hit);
endmodule

// File: rtl/trig_combine.sv
// Global combiner: reduces the channel hits or selects the synchronized external
// trigger, then gates the result with arm into a single-cycle pulse.
// Assumes: arm is synchronous to clk; a low arm level clears the fired state.
module trig_combine
    import trig_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hits,
    input  logic              ext_s,
    input  logic [1:0]        mode,
    input  logic              arm,
    output logic              trig_out
);
    logic cond;
    logic fired_q;

    // Select the combined trigger condition for the current mode.
    always_comb begin
        case (trig_mode_e'(mode))
            MODE_AND: cond = &hits;
            MODE_OR:  cond = |hits;
            MODE_EXT: cond = ext_s;
            default:  cond = 1'b0;
        endcase
    end

    // Remember that a pulse was issued; dropping arm clears the memory.
    always_ff @(posedge clk) begin
        if (!rst_n) fired_q <= 1'b0;
        else        fired_q <= arm & (fired_q | cond);
    end

    assign trig_out = arm & ~fired_q & cond;

    // R8: no pulse while disarmed.
    assert_no_trig_disarmed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |-> !trig_out);

    // R9: the pulse never lasts two cycles.
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    // R7: in external mode a pulse needs the synchronized external level.
    assert_ext_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_EXT && trig_out) |-> ext_s);

    // R7: the disabled mode never fires.
    assert_mode_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NONE) |-> !trig_out);

    // R5: an AND-mode pulse needs every channel to match.
    assert_and_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_AND && trig_out) |-> (hits == {NUM_CH{1'b1}}));
endmodule

// File: rtl/trig_bank.sv
// Trigger comparator bank top: one registered comparator per probe channel,
// a synchronizer for the external trigger, and the global combiner.
// Assumes: all channels share the width CH_W; the fields are packed with channel 0 in the low bits.
module trig_bank
    import trig_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH*CH_W-1:0] chan_sample,
    input  logic [NUM_CH*OP_W-1:0] chan_op,
    input  logic [NUM_CH*CH_W-1:0] chan_ref,
    input  logic [1:0]             trig_mode,
    input  logic                   ext_trig,
    input  logic                   arm,
    output logic                   trig_out
);
    logic [NUM_CH-1:0] hits;
    logic              ext_s;

    // One comparator per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        trig_cmp #(.W(CH_W)) i_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (chan_sample[c*CH_W +: CH_W]),
            .refv   (chan_ref[c*CH_W +: CH_W]),
            .op     (chan_op[c*OP_W +: OP_W]),
            .hit    (hits[c])
        );
    end

    trig_sync i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_trig),
        .sync_out (ext_s)
    );

    trig_combine #(.NUM_CH(NUM_CH)) i_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .hits     (hits),
        .ext_s    (ext_s),
        .mode     (trig_mode),
        .arm      (arm),
        .trig_out (trig_out)
    );
endmodule

// File: tb/test_trig_bank.sv
// Bench for the trigger bank. It uses 2 channels of 3 bits, sweeps every
// operator, sample and reference on channel 0, then checks the modes, the
// latencies and the re-arm sequence.
module test_trig_bank;
    localparam int NCH = 2;
    localparam int W   = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH*W-1:0] chan_sample;
    logic [NCH*3-1:0] chan_op;
    logic [NCH*W-1:0] chan_ref;
    logic [1:0]       trig_mode;
    logic             ext_trig;
    logic             arm;
    logic             trig_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    trig_bank #(.NUM_CH(NCH), .CH_W(W)) i_trig_bank (
        .clk(clk), .rst_n(rst_n), .chan_sample(chan_sample), .chan_op(chan_op),
        .chan_ref(chan_ref), .trig_mode(trig_mode), .ext_trig(ext_trig),
        .arm(arm), .trig_out(trig_out)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: trig_out=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Expected comparator result, computed from the operator codes in the requirements.
    function automatic logic exp_match(input int op, input int s, input int r);
        case (op)
            0: return 1'b1;
            2: return s == r;
            3: return s <= r;
            4: return s >= r;
            5: return s >  r;
            6: return s != r;
            default: return 1'b0;
        endcase
    endfunction

    // Disarm for one edge, then re-arm at the falling edge (called at a falling edge).
    task automatic rearm();
        arm = 1'b0;
        @(posedge clk); @(negedge clk);
        arm = 1'b1;
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0; arm = 1'b1; trig_mode = 2'd0; ext_trig = 1'b0;
        chan_op = {3'd0, 3'd0}; chan_sample = '0; chan_ref = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(trig_out, 1'b0, "R1 reset AND mode");
        trig_mode = 2'd1; #1;
        check(trig_out, 1'b0, "R1 reset OR mode");
        trig_mode = 2'd2; #1;
        check(trig_out, 1'b0, "R1 reset ext mode");
        rst_n = 1'b1; arm = 1'b0; trig_mode = 2'd0;

        // R2 R3 R4: sweep channel 0; channel 1 is always-true so AND follows channel 0.
        for (int op = 0; op < 8; op++) begin
            for (int s = 0; s < 8; s++) begin
                for (int r = 0; r < 8; r++) begin
                    @(negedge clk);
                    arm = 1'b0;
                    chan_op = {3'd0, 3'(op)};
                    chan_sample = {3'd0, 3'(s)};
                    chan_ref = {3'd0, 3'(r)};
                    @(posedge clk); @(negedge clk);
                    arm = 1'b1; #1;
                    check(trig_out, exp_match(op, s, r),
                          (op < 2 || op == 7) ? "R2 operator" :
                          (op == 2 || op == 6) ? "R3 equality" : "R4 ordered");
                    if (exp_match(op, s, r)) begin
                        @(negedge clk); #1;
                        check(trig_out, 1'b0, "R9 held after pulse");
                    end
                end
            end
        end

        // R5 R6: both channels use equality against 5.
        chan_op = {3'd2, 3'd2};
        chan_ref = {3'd5, 3'd5};
        for (int m = 0; m < 2; m++) begin
            for (int pat = 0; pat < 4; pat++) begin
                @(negedge clk);
                arm = 1'b0;
                trig_mode = 2'(m);
                chan_sample = {(pat[1] ? 3'd5 : 3'd2), (pat[0] ? 3'd5 : 3'd6)};
                @(posedge clk); @(negedge clk);
                arm = 1'b1; #1;
                if (m == 0) check(trig_out, pat == 3, "R5 AND reduction");
                else        check(trig_out, pat != 0, "R6 OR reduction");
            end
        end

        // R8: a true condition while disarmed produces nothing.
        @(negedge clk);
        arm = 1'b0; trig_mode = 2'd0; chan_op = {3'd0, 3'd0};
        repeat (3) begin
            @(negedge clk); #1;
            check(trig_out, 1'b0, "R8 disarmed");
        end

        // R9: a persistent condition gives one pulse; re-arming gives another.
        @(negedge clk);
        arm = 1'b1; #1;
        check(trig_out, 1'b1, "R9 first pulse");
        repeat (3) begin
            @(negedge clk); #1;
            check(trig_out, 1'b0, "R9 held off");
        end
        rearm();
        check(trig_out, 1'b1, "R9 pulse after re-arm");

        // R10: a match is visible only after the next edge.
        @(negedge clk);
        arm = 1'b0; chan_op = {3'd0, 3'd2}; chan_ref = {3'd0, 3'd4}; chan_sample = '0;
        @(posedge clk); @(negedge clk);
        arm = 1'b1; #1;
        check(trig_out, 1'b0, "R10 no match armed");
        chan_sample = {3'd0, 3'd4}; #1;
        check(trig_out, 1'b0, "R10 same cycle as sample");
        @(negedge clk); #1;
        check(trig_out, 1'b1, "R10 one edge later");

        // R7: external mode ignores the comparators and adds two flops of latency.
        @(negedge clk);
        arm = 1'b0; trig_mode = 2'd2; chan_op = {3'd0, 3'd0}; ext_trig = 1'b0;
        @(posedge clk); @(negedge clk);
        arm = 1'b1; #1;
        check(trig_out, 1'b0, "R7 comparators ignored");
        @(negedge clk); #1;
        check(trig_out, 1'b0, "R7 comparators ignored later");
        ext_trig = 1'b1; #1;
        check(trig_out, 1'b0, "R7 ext not yet sampled");
        @(negedge clk); #1;
        check(trig_out, 1'b0, "R7 ext after one edge");
        @(negedge clk); #1;
        check(trig_out, 1'b1, "R7 ext after two edges");
        @(negedge clk); #1;
        check(trig_out, 1'b0, "R9 ext single pulse");

        // R7: mode 3 never fires.
        @(negedge clk);
        trig_mode = 2'd3;
        rearm();
        check(trig_out, 1'b0, "R7 disabled mode");
        repeat (2) begin
            @(negedge clk); #1;
            check(trig_out, 1'b0, "R7 disabled mode later");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule